// File: doc/BRIEF.md
# Programmable Byte-Serial CRC Engine

This block computes a cyclic redundancy checksum over a stream of bytes that software writes one at a time over a simple 32-bit register bus. The polynomial and the starting value are programmable. The active checksum width can be 8, 16 or 32 bits and is chosen at run time. Four word-aligned registers are exposed: a width-select register, a polynomial register, a data-input register and the checksum register. Writing the checksum register seeds it, and reading it returns the running result.

Each byte written to the data register is folded into the checksum one bit per clock, most significant bit first. No reflection and no final XOR are applied. The bus acknowledge for such a write is held back until all eight bits have been consumed, so the next access always sees a settled checksum. Software first programs the width, the polynomial and the seed, then streams the bytes, and finally reads the result.

Top module: `crc_byte_engine`

## Requirements
- R1: After reset the width code, polynomial, stored data byte and checksum are all zero, and `bus_ack` is low.
- R2: The register selected by `bus_addr[3:2]` = 0 holds the width code in bits 1:0. Code 0 selects 8 bits, 1 selects 16 bits and 2 selects 32 bits. Read bits 31:2 are zero.
- R3: The register selected by `bus_addr[3:2]` = 1 holds a full 32-bit polynomial and reads back unchanged.
- R4: The register selected by `bus_addr[3:2]` = 2 takes a data byte from `bus_wdata[7:0]`. Write bits 31:8 are ignored, a read returns the last byte in bits 7:0, and read bits 31:8 are zero.
- R5: A write to the register selected by `bus_addr[3:2]` = 3 loads all 32 checksum bits as the seed. A read returns the checksum with every bit at or above the active width forced to zero.
- R6: Each data write advances the checksum by eight steps, using the byte's bits from bit 7 down to bit 0. In each step the feedback is the checksum's top active bit XOR the data bit. The active bits then shift left by one, and the polynomial's active bits are XORed in when the feedback is 1.
- R7: In 8-bit and 16-bit modes only the low 8 or 16 bits of the polynomial and the checksum take part. In 32-bit mode all bits take part, and width code 3 behaves like code 2.
- R8: Checksum bits above the active width are not changed by data processing. They become visible again after a switch to a wider mode.
- R9: A data write is acknowledged by a one-cycle `bus_ack` pulse 9 cycles after the request is accepted. Every other write and every read is acknowledged in the cycle after acceptance, with the read value on `bus_rdata` during the `bus_ack` cycle.
- R10: A request is accepted only while no access is in progress and `bus_ack` is low. Changes to the request inputs while a data byte is being processed have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Access request, held until `bus_ack` |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Byte address; bits 3:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_ack` is high |
| bus_ack | output | 1 | One-cycle access completion |

## Verification
The bench builds the engine with its default parameters: a 32-bit bus and checksum and 8 bits per data step. With these values all three widths and the aliased width code can be reached, along with the stall of eight extra cycles. The bench runs standard check strings at each width and compares the results against fixed known checksums and against a behavioural bit-by-bit model. It also seeds all 32 bits in 8-bit mode and then widens the mode, which shows whether processing left the upper bits alone.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;

    typedef enum logic [1:0] {
        CRC_W8   = 2'b00,
        CRC_W16  = 2'b01,
        CRC_W32  = 2'b10,
        CRC_W32X = 2'b11
    } crc_mode_e;

    typedef enum logic [1:0] {
        SEL_MODE = 2'd0,
        SEL_POLY = 2'd1,
        SEL_DATA = 2'd2,
        SEL_SUM  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/crc_width_mask.sv
// Turns the width code into a mask of active checksum bits and the index of the top active bit.
module crc_width_mask
    import crc_eng_pkg::*;
#(
    parameter int CRC_W = 32
) (
    input  crc_mode_e                  mode,
    output logic [CRC_W-1:0]           mask,
    output logic [$clog2(CRC_W)-1:0]   top_idx
);
    localparam int IDX_W = $clog2(CRC_W);

    int act_w;

    always_comb begin
        case (mode)
            CRC_W8:  act_w = 8;
            CRC_W16: act_w = 16;
            default: act_w = CRC_W;
        endcase
        for (int i = 0; i < CRC_W; i++) begin
            mask[i] = (i < act_w);
        end
        top_idx = IDX_W'(act_w - 1);
    end
endmodule

// File: rtl/crc_bit_step.sv
// One LFSR step over the active bits; inactive bits pass through unchanged.
module crc_bit_step #(
    parameter int CRC_W = 32
) (
    input  logic [CRC_W-1:0]         sum_cur,
    input  logic [CRC_W-1:0]         poly,
    input  logic [CRC_W-1:0]         mask,
    input  logic [$clog2(CRC_W)-1:0] top_idx,
    input  logic                     din,
    output logic [CRC_W-1:0]         sum_nxt
);
    logic fb;
    assign fb = sum_cur[top_idx] ^ din;

    for (genvar i = 0; i < CRC_W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign sum_nxt[i] = mask[i] ? (fb & poly[i]) : sum_cur[i];
        end else begin : g_up
            assign sum_nxt[i] = mask[i] ? (sum_cur[i-1] ^ (fb & poly[i])) : sum_cur[i];
        end
    end
endmodule

// File: rtl/crc_byte_engine.sv
module crc_byte_engine
    import crc_eng_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 4,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              bus_ack
);
    localparam int CRC_W   = BUS_W;
    localparam int CNT_W   = $clog2(BYTE_W + 1);
    localparam int SEL_LSB = 2;
    localparam int IDX_W   = $clog2(CRC_W);

    typedef struct packed {
        crc_mode_e         mode;
        logic [CRC_W-1:0]  poly;
        logic [CRC_W-1:0]  sum;
        logic [BYTE_W-1:0] data;
        logic [BYTE_W-1:0] shf;
        logic [CNT_W-1:0]  cnt;
        logic              busy;
        logic              ack;
        logic [BUS_W-1:0]  rdata;
    } eng_state_t;

    eng_state_t st_d, st_q;

    logic [CRC_W-1:0] act_mask;
    logic [IDX_W-1:0] top_idx;
    logic [CRC_W-1:0] step_sum;
    logic             accept;
    reg_sel_e         sel;

    crc_width_mask #(.CRC_W(CRC_W)) u_mask (
        .mode    (st_q.mode),
        .mask    (act_mask),
        .top_idx (top_idx)
    );

    crc_bit_step #(.CRC_W(CRC_W)) u_step (
        .sum_cur (st_q.sum),
        .poly    (st_q.poly),
        .mask    (act_mask),
        .top_idx (top_idx),
        .din     (st_q.shf[BYTE_W-1]),
        .sum_nxt (step_sum)
    );

    assign accept = bus_req && !st_q.busy && !st_q.ack;
    assign sel    = reg_sel_e'(bus_addr[SEL_LSB +: 2]);

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;
        if (st_q.busy) begin
            st_d.sum = step_sum;
            st_d.shf = st_q.shf << 1;
            st_d.cnt = st_q.cnt - CNT_W'(1);
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.busy = 1'b0;
                st_d.ack  = 1'b1;
            end
        end else if (accept) begin
            st_d.rdata = '0;
            if (bus_we) begin
                case (sel)
                    SEL_MODE: begin
                        st_d.mode = crc_mode_e'(bus_wdata[1:0]);
                        st_d.ack  = 1'b1;
                    end
                    SEL_POLY: begin
                        st_d.poly = CRC_W'(bus_wdata);
                        st_d.ack  = 1'b1;
                    end
                    SEL_DATA: begin
                        st_d.data = bus_wdata[BYTE_W-1:0];
                        st_d.shf  = bus_wdata[BYTE_W-1:0];
                        st_d.cnt  = CNT_W'(BYTE_W);
                        st_d.busy = 1'b1;
                    end
                    default: begin
                        st_d.sum = CRC_W'(bus_wdata);
                        st_d.ack = 1'b1;
                    end
                endcase
            end else begin
                case (sel)
                    SEL_MODE: st_d.rdata = BUS_W'(st_q.mode);
                    SEL_POLY: st_d.rdata = BUS_W'(st_q.poly);
                    SEL_DATA: st_d.rdata = BUS_W'(st_q.data);
                    default:  st_d.rdata = BUS_W'(st_q.sum & act_mask);
                endcase
                st_d.ack = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign bus_ack   = st_q.ack;

    // Acknowledge is a single-cycle pulse (R9)
    p_ack_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    // No acknowledge while a byte is still being shifted (R9)
    p_busy_no_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> !bus_ack);

    // 8-bit processing leaves the upper checksum bits alone (R8)
    p_upper_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.mode == CRC_W8) |=> $stable(st_q.sum[CRC_W-1:8]));

    // Configuration cannot change while a byte is in flight (R10)
    p_cfg_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> ($stable(st_q.poly) && $stable(st_q.mode)));

endmodule

// File: tb/tb_crc_byte_engine.sv
`timescale 1ns/1ps
module tb_crc_byte_engine;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_req;
    logic        bus_we;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_ack;

    always #2.5 clk = ~clk;

    crc_byte_engine dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // behavioural model state
    logic [1:0]  m_mode;
    logic [31:0] m_poly;
    logic [31:0] m_sum;
    logic [7:0]  m_data;

    function automatic int width_of(logic [1:0] m);
        if (m == 2'd0) return 8;
        if (m == 2'd1) return 16;
        return 32;
    endfunction

    function automatic logic [31:0] mask_of(logic [1:0] m);
        int w;
        w = width_of(m);
        if (w == 32) return 32'hFFFF_FFFF;
        return (32'd1 << w) - 32'd1;
    endfunction

    function automatic logic [31:0] model_byte(logic [31:0] s, logic [31:0] p,
                                               logic [1:0] m, logic [7:0] b);
        logic [31:0] msk;
        logic [31:0] t;
        logic        fb;
        int          w;
        w   = width_of(m);
        msk = mask_of(m);
        for (int k = 7; k >= 0; k--) begin
            fb = s[w-1] ^ b[k];
            t  = s << 1;
            if (fb) t = t ^ p;
            s = (s & ~msk) | (t & msk);
        end
        return s;
    endfunction

    function automatic logic [31:0] model_read(logic [1:0] sel);
        case (sel)
            2'd0:    return {30'd0, m_mode};
            2'd1:    return m_poly;
            2'd2:    return {24'd0, m_data};
            default: return m_sum & mask_of(m_mode);
        endcase
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // One bus access; lat counts cycles between the accepting edge and the ack cycle.
    task automatic xact(bit we, logic [1:0] sel, logic [31:0] wd, bit disturb,
                        output logic [31:0] rd, output int lat);
        @(negedge clk);
        bus_req   = 1'b1;
        bus_we    = we;
        bus_addr  = {sel, 2'b00};
        bus_wdata = wd;
        @(posedge clk);
        lat = 0;
        while (1) begin
            @(negedge clk);
            if (disturb) begin
                bus_addr  = 4'hC;
                bus_wdata = 32'h1234_5678;
            end
            if (bus_ack || lat > 40) break;
            lat++;
        end
        rd      = bus_rdata;
        bus_req = 1'b0;
    endtask

    task automatic wr(logic [1:0] sel, logic [31:0] wd, string tag, bit disturb = 1'b0);
        logic [31:0] rd;
        int          lat;
        int          exp_lat;
        exp_lat = (sel == 2'd2) ? 8 : 0;
        xact(1'b1, sel, wd, disturb, rd, lat);
        check(lat == exp_lat, tag, 32'(lat), 32'(exp_lat));
        case (sel)
            2'd0: m_mode = wd[1:0];
            2'd1: m_poly = wd;
            2'd2: begin
                m_data = wd[7:0];
                m_sum  = model_byte(m_sum, m_poly, m_mode, wd[7:0]);
            end
            default: m_sum = wd;
        endcase
    endtask

    task automatic rd_chk(logic [1:0] sel, string tag, output logic [31:0] val);
        int          lat;
        logic [31:0] exp;
        exp = model_read(sel);
        xact(1'b0, sel, 32'hFFFF_FFFF, 1'b0, val, lat);
        check(lat == 0, "R9", 32'(lat), 32'd0);
        check(val === exp, tag, val, exp);
    endtask

    task automatic run_string(string tag);
        string s;
        s = "123456789";
        for (int i = 0; i < 9; i++) begin
            wr(2'd2, {24'hA5A5A5, s[i]}, tag);
        end
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++;
                errors++;
                $display("FAIL watchdog actual=%08h expected=%08h", cycles, 100000);
                finish_run();
            end
        end
    end

    initial begin
        logic [31:0] v;
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        rst_n     = 1'b0;
        m_mode = '0; m_poly = '0; m_sum = '0; m_data = '0;
        repeat (5) @(negedge clk);
        check(bus_ack == 1'b0, "R1", 32'(bus_ack), 32'd0);
        rst_n = 1'b1;

        // R1: reset state of every register
        rd_chk(2'd0, "R1", v);
        rd_chk(2'd1, "R1", v);
        rd_chk(2'd2, "R1", v);
        rd_chk(2'd3, "R1", v);

        // R2: width code field, upper bits read zero
        wr(2'd0, 32'hFFFF_FFFD, "R9");
        rd_chk(2'd0, "R2", v);
        check(v == 32'd1, "R2", v, 32'd1);

        // R3: full polynomial read back
        wr(2'd1, 32'hC3A5_5A3C, "R9");
        rd_chk(2'd1, "R3", v);

        // R4: data byte, upper bits ignored
        wr(2'd2, 32'hABCD_EF12, "R9");
        rd_chk(2'd2, "R4", v);
        check(v == 32'h0000_0012, "R4", v, 32'h12);

        // R5: seed in 8-bit mode reads masked
        wr(2'd0, 32'd0, "R9");
        wr(2'd3, 32'hDEAD_BEEF, "R9");
        rd_chk(2'd3, "R5", v);
        check(v == 32'h0000_00EF, "R5", v, 32'hEF);

        // R8: process in 8-bit mode, upper bits survive
        wr(2'd1, 32'h0000_0007, "R9");
        wr(2'd2, 32'h0000_0031, "R8");
        wr(2'd2, 32'h0000_00C8, "R8");
        wr(2'd0, 32'd2, "R9");
        rd_chk(2'd3, "R8", v);
        check(v[31:8] == 24'hDEADBE, "R8", v, {24'hDEADBE, v[7:0]});

        // R6/R7: known check values for each width
        wr(2'd0, 32'd0, "R9");
        wr(2'd1, 32'h0000_0007, "R9");
        wr(2'd3, 32'd0, "R9");
        run_string("R6");
        rd_chk(2'd3, "R7", v);
        check(v == 32'h0000_00F4, "R7", v, 32'hF4);

        wr(2'd0, 32'd1, "R9");
        wr(2'd1, 32'h0000_1021, "R9");
        wr(2'd3, 32'h0000_FFFF, "R9");
        run_string("R6");
        rd_chk(2'd3, "R7", v);
        check(v == 32'h0000_29B1, "R7", v, 32'h29B1);

        wr(2'd0, 32'd2, "R9");
        wr(2'd1, 32'h04C1_1DB7, "R9");
        wr(2'd3, 32'hFFFF_FFFF, "R9");
        run_string("R6");
        rd_chk(2'd3, "R6", v);
        check(v == 32'h0376_E6E7, "R6", v, 32'h0376E6E7);

        // R7: width code 3 acts as 32-bit
        wr(2'd0, 32'd3, "R9");
        wr(2'd3, 32'hFFFF_FFFF, "R9");
        run_string("R7");
        rd_chk(2'd3, "R7", v);
        check(v == 32'h0376_E6E7, "R7", v, 32'h0376E6E7);

        // R6: 16-bit polynomial with junk upper bits has no effect on result
        wr(2'd0, 32'd1, "R9");
        wr(2'd1, 32'hFFFF_8005, "R9");
        wr(2'd3, 32'h1234_0000, "R9");
        wr(2'd2, 32'h0000_00FF, "R6");
        wr(2'd2, 32'h0000_0000, "R6");
        wr(2'd2, 32'h0000_0080, "R6");
        rd_chk(2'd3, "R6", v);

        // R10: changing the request during processing has no effect
        wr(2'd2, 32'h0000_005A, "R10", 1'b1);
        rd_chk(2'd3, "R10", v);
        rd_chk(2'd2, "R10", v);

        repeat (3) @(negedge clk);
        check(bus_ack == 1'b0, "R9", 32'(bus_ack), 32'd0);
        finish_run();
    end

endmodule